// File: doc/BRIEF.md
# MDIO Management Frame Master

This block carries out one PHY management register access at a time over the two-wire management interface: a clock output (MDC) and a bidirectional data line (MDIO). The host writes a single 32-bit frame word, and the fields of that word go onto the wire unchanged. Writing the word starts the access at once. The block sends a 32-bit preamble of ones, then the 32 frame bits with the most significant bit first. For a read it lets go of MDIO during the turnaround and captures the 16 data bits the PHY returns.

When the access finishes, a sticky done bit is set. The host clears it by writing a one to the same bit position of the control word. After a read, bits 15:0 of the frame word read back as the captured PHY data. A speed field in the control word sets the MDC half-period as a whole number of system clocks. The value is copied when a transaction starts, so a transaction in flight never changes rate.

Top module: `mdio_frame_master`

## Requirements
- R1: The wire sequence is 32 ones followed by frame-word bits 31 down to 0. The frame fields are start in 31:30, opcode in 29:28, PHY address in 27:23, register address in 22:18, turnaround in 17:16 and data in 15:0. All of them are sent exactly as written.
- R2: A frame write while idle starts the transaction on the next clock edge. From that edge busy (control bit 9) reads 1 and MDIO is driven high as the first preamble bit. While idle, MDIO is not driven.
- R3: Each MDC half-period lasts speed+1 system clocks, where speed is control bits 7:0. A transaction is 64 MDC periods, so busy stays high for exactly 128*(speed+1) clocks. MDC is low whenever the block is idle.
- R4: Within a transaction, the MDIO output changes only at the edge where MDC falls. Incoming data is sampled at the edge where MDC rises.
- R5: For opcode 10 (read), the MDIO drive is released from the second turnaround bit through the last data bit. The 16 bits sampled at the data-field rising edges are stored most significant first into frame-word bits 15:0 at completion. Bits 31:16 are left as written.
- R6: For any opcode other than 10, including 01 (write) and 11, MDIO is driven for all 64 bit periods, and the frame word reads back unchanged.
- R7: Done (control bit 8) is set at the edge that ends a transaction and stays set until a control write with bit 8 equal to 1. A control write with bit 8 equal to 0 leaves it set. If completion and a clear fall on the same edge, completion wins.
- R8: A frame write while busy is ignored. The transaction on the wire and the frame readback are unchanged.
- R9: A speed write while busy takes effect only for the next transaction, and it reads back at once.
- R10: After reset, busy, done, MDC and the MDIO drive enable are 0, the frame word reads 0, and speed reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_wr | input | 1 | Frame word write strobe; starts a transaction when idle |
| frame_wdata | input | 32 | Frame word to send |
| frame_rdata | output | 32 | Frame word readback, with read data merged into bits 15:0 |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Bits 7:0 speed, bit 8 write one to clear done |
| ctl_rdata | output | 10 | Bits 7:0 speed, bit 8 done, bit 9 busy |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A bit index that drifts shows up at once as a wrong bit in the captured wire sequence, and also as a busy period that is not exactly 128*(speed+1) clocks, which is visible when the transaction ends. A wrong divider count or a speed change that leaks into a running transaction changes the MDC edge spacing within one half-period. A turnaround release placed on the wrong bit shows in the drive-enable pattern of that frame. Capture errors, and a done flag that is lost or cleared wrongly, appear on the first readback of the frame word or control word after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned FRAME_W = 32;
  localparam int unsigned DATA_W  = 16;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  // opcode lives in frame bits 29:28
  function automatic logic frame_is_read(input logic [FRAME_W-1:0] f);
    return f[29:28] == OPC_READ;
  endfunction

  // bit position (counted from the first preamble bit) where a read stops driving:
  // the second turnaround bit and everything after it
  function automatic logic drive_off(input logic rd, input int unsigned pos,
                                     input int unsigned pre);
    return rd && (pos >= pre + 15);
  endfunction

  // bit positions whose rising MDC edge captures read data
  function automatic logic capture_slot(input logic rd, input int unsigned pos,
                                        input int unsigned pre);
    return rd && (pos >= pre + 16);
  endfunction

  // upper fields kept, low half replaced by the captured word
  function automatic logic [FRAME_W-1:0] merge_read(input logic [FRAME_W-1:0] f,
                                                    input logic [DATA_W-1:0] d);
    return {f[FRAME_W-1:DATA_W], d};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = run && (cnt_q == half_div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_in,
  output logic               busy,
  output logic               mdio_out,
  output logic               mdio_drive,
  output logic               finish,
  output logic               rd_op,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int unsigned TOT   = PRE_LEN + FRAME_W;
  localparam int unsigned IDX_W = $clog2(TOT);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOT - 1);

  logic [TOT-1:0]   sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;
  logic             oe_q;

  assign idx_nxt    = idx_q + 1'b1;
  assign finish     = busy && fall_tick && (idx_q == LAST);
  assign mdio_out   = busy ? sh_q[TOT-1] : 1'b1;
  assign mdio_drive = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      idx_q   <= '0;
      busy    <= 1'b0;
      oe_q    <= 1'b0;
      rd_op   <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      sh_q    <= {{PRE_LEN{1'b1}}, frame};
      idx_q   <= '0;
      busy    <= 1'b1;
      oe_q    <= 1'b1;
      rd_op   <= frame_is_read(frame);
      rd_data <= '0;
    end else if (busy) begin
      if (fall_tick) begin
        if (idx_q == LAST) begin
          busy <= 1'b0;
          oe_q <= 1'b0;
        end else begin
          idx_q <= idx_nxt;
          sh_q  <= sh_q << 1;
          oe_q  <= !drive_off(rd_op, int'(idx_nxt), PRE_LEN);
        end
      end
      if (rise_tick && capture_slot(rd_op, int'(idx_q), PRE_LEN)) begin
        rd_data <= {rd_data[DATA_W-2:0], mdio_in};
      end
    end
  end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SPEED_RESET = 3,
  parameter int unsigned PRE_LEN     = 32,
  localparam int unsigned CTL_W      = DIV_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_wr,
  input  logic [FRAME_W-1:0] frame_wdata,
  output logic [FRAME_W-1:0] frame_rdata,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);

  localparam int unsigned DONE_BIT = DIV_W;

  logic [FRAME_W-1:0] frame_q;
  logic [DIV_W-1:0]   speed_q;
  logic [DIV_W-1:0]   run_div_q;
  logic               done_q;
  logic               busy;
  logic               start;
  logic               finish;
  logic               rd_op;
  logic [DATA_W-1:0]  rd_data;
  logic               rise_tick;
  logic               fall_tick;
  logic               done_clr_req;

  assign start        = frame_wr && !busy;
  assign done_clr_req = ctl_wr && ctl_wdata[DONE_BIT];

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .half_div  (run_div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shift_engine #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .frame      (frame_wdata),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_in    (mdio_i),
    .busy       (busy),
    .mdio_out   (mdio_o),
    .mdio_drive (mdio_oe),
    .finish     (finish),
    .rd_op      (rd_op),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= '0;
      speed_q   <= DIV_W'(SPEED_RESET);
      run_div_q <= DIV_W'(SPEED_RESET);
      done_q    <= 1'b0;
    end else begin
      if (start) begin
        frame_q   <= frame_wdata;
        run_div_q <= speed_q;
      end else if (finish && rd_op) begin
        frame_q <= merge_read(frame_q, rd_data);
      end
      if (ctl_wr) begin
        speed_q <= ctl_wdata[DIV_W-1:0];
      end
      if (finish) begin
        done_q <= 1'b1;
      end else if (done_clr_req) begin
        done_q <= 1'b0;
      end
    end
  end

  assign frame_rdata = frame_q;
  assign ctl_rdata   = {busy, done_q, speed_q};

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        clr_req,
  input logic        finish,
  input logic        rd_op,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] frame_rdata
);

  a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_op) |-> mdio_oe);

  a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_req) |=> done);

  a_r8_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(frame_rdata));

endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done_q),
  .clr_req     (done_clr_req),
  .finish      (finish),
  .rd_op       (rd_op),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe),
  .frame_rdata (frame_rdata)
);

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_wr = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic [31:0] frame_rdata;
  logic        ctl_wr = 1'b0;
  logic [9:0]  ctl_wdata = '0;
  logic [9:0]  ctl_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int failures = 0;

  // monitor state
  logic        mon_clr = 1'b0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;
  int          rcount = 0;
  int          bad_chg = 0;
  logic        mdc_d = 1'b0, mdio_d = 1'b1, busy_d = 1'b0;
  logic [15:0] phy_data = '0;

  always #2 clk = ~clk;

  mdio_frame_master i_mdio_frame_master (
    .clk, .rst_n, .frame_wr, .frame_wdata, .frame_rdata,
    .ctl_wr, .ctl_wdata, .ctl_rdata, .mdc, .mdio_o, .mdio_oe, .mdio_i
  );

  // PHY side: data bit for rising edge r of the frame, r = 48..63
  assign mdio_i = (rcount >= 48 && rcount < 64) ? phy_data[63 - rcount] : 1'b1;

  always @(posedge clk) begin
    if (mon_clr) begin
      cap_bits <= '0; cap_oe <= '0; rcount <= 0; bad_chg <= 0;
    end else begin
      if (mdc && !mdc_d) begin
        cap_bits <= {cap_bits[62:0], mdio_o};
        cap_oe   <= {cap_oe[62:0], mdio_oe};
        rcount   <= rcount + 1;
      end
      if (ctl_rdata[9] && busy_d && (mdio_o != mdio_d) && !(mdc_d && !mdc))
        bad_chg <= bad_chg + 1;
    end
    mdc_d  <= mdc;
    mdio_d <= mdio_o;
    busy_d <= ctl_rdata[9];
  end

  function automatic logic [31:0] make_frame(input logic [1:0] op, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  function automatic logic [63:0] exp_wire(input logic [31:0] f);
    return {32'hFFFF_FFFF, f};
  endfunction

  function automatic logic [63:0] exp_drive(input logic [31:0] f);
    return (f[29:28] == 2'b10) ? {{47{1'b1}}, {17{1'b0}}} : {64{1'b1}};
  endfunction

  function automatic int exp_clocks(input int spd);
    return 128 * (spd + 1);
  endfunction

  function automatic logic [31:0] exp_readback(input logic [31:0] f, input logic [15:0] d);
    return (f[29:28] == 2'b10) ? {f[31:16], d} : f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] spd, input logic clr);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {1'b0, clr, spd};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic run_txn(input logic [31:0] fr, input int spd, input logic [15:0] pd,
                         input bit mid_frame, input bit mid_spd_en, input logic [7:0] mid_spd,
                         input bit end_clear);
    int n;
    phy_data = pd;
    @(negedge clk);
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    frame_wr = 1'b1; frame_wdata = fr;
    n = 0;
    for (int guard = 0; guard < 5000; guard++) begin
      @(negedge clk);
      frame_wr = 1'b0; ctl_wr = 1'b0;
      if (!ctl_rdata[9]) break;
      n++;
      if (n == 1)
        chk(mdio_oe && mdio_o, "R2 start drives preamble",
            {62'd0, mdio_oe, mdio_o}, 64'd3);
      if (mid_frame && n == 10) begin frame_wr = 1'b1; frame_wdata = ~fr; end
      if (mid_spd_en && n == 10) begin ctl_wr = 1'b1; ctl_wdata = {2'b00, mid_spd}; end
      if (end_clear && n == exp_clocks(spd)) begin
        ctl_wr = 1'b1; ctl_wdata = {2'b01, 8'(spd)};
      end
    end
    chk(n == exp_clocks(spd), "R3 busy length", 64'(n), 64'(exp_clocks(spd)));
    chk(rcount == 64, "R3 MDC period count", 64'(rcount), 64'd64);
    chk(((cap_bits ^ exp_wire(fr)) & exp_drive(fr)) == '0, "R1 wire bits",
        cap_bits, exp_wire(fr));
    chk(cap_oe == exp_drive(fr), "R5/R6 drive pattern", cap_oe, exp_drive(fr));
    chk(bad_chg == 0, "R4 MDIO change off falling edge", 64'(bad_chg), 64'd0);
    chk(frame_rdata == exp_readback(fr, pd), "R5/R8 frame readback",
        64'(frame_rdata), 64'(exp_readback(fr, pd)));
    chk(ctl_rdata[8] == 1'b1, "R7 done after completion", 64'(ctl_rdata[8]), 64'd1);
    chk(!mdc && !mdio_oe, "R3 idle MDC low, R2 released",
        {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] fr;
    int spd;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ctl_rdata == 10'h003, "R10 control reset", 64'(ctl_rdata), 64'h003);
    chk(frame_rdata == 32'd0 && !mdc && !mdio_oe, "R10 outputs reset",
        {frame_rdata, 30'd0, mdc, mdio_oe}, 64'd0);

    // R1/R6 write at speed 0
    write_ctl(8'd0, 1'b1);
    run_txn(make_frame(2'b01, 5'd1, 5'd4, 16'h0181), 0, 16'h0, 0, 0, 8'd0, 0);

    // R7 clear only with a one in bit 8
    write_ctl(8'd0, 1'b0);
    @(negedge clk);
    chk(ctl_rdata[8] == 1'b1, "R7 zero write keeps done", 64'(ctl_rdata[8]), 64'd1);
    write_ctl(8'd2, 1'b1);
    @(negedge clk);
    chk(ctl_rdata[8] == 1'b0, "R7 one write clears done", 64'(ctl_rdata[8]), 64'd0);

    // R5 read at speed 2
    run_txn(make_frame(2'b10, 5'd1, 5'd17, 16'h0000), 2, 16'hA5C3, 0, 0, 8'd0, 0);

    // R6 opcode 11 drives throughout
    write_ctl(8'd1, 1'b1);
    run_txn(make_frame(2'b11, 5'd9, 5'd2, 16'h3C5A), 1, 16'hFFFF, 0, 0, 8'd0, 0);

    // R8 frame write while busy ignored
    run_txn(make_frame(2'b10, 5'd3, 5'd19, 16'h1234), 1, 16'h0F0F, 1, 0, 8'd0, 0);

    // R9 speed write while busy applies next time
    run_txn(make_frame(2'b01, 5'd5, 5'd0, 16'h2100), 1, 16'h0, 0, 1, 8'd3, 0);
    chk(ctl_rdata[7:0] == 8'd3, "R9 speed readback", 64'(ctl_rdata[7:0]), 64'd3);
    run_txn(make_frame(2'b01, 5'd5, 5'd0, 16'h1000), 3, 16'h0, 0, 0, 8'd0, 0);

    // R7 completion wins over simultaneous clear
    write_ctl(8'd0, 1'b1);
    @(negedge clk);
    chk(ctl_rdata[8] == 1'b0, "R7 done cleared before test", 64'(ctl_rdata[8]), 64'd0);
    run_txn(make_frame(2'b10, 5'd31, 5'd31, 16'hFFFF), 0, 16'h8001, 0, 0, 8'd0, 1);

    // constrained random
    for (int k = 0; k < 12; k++) begin
      spd = int'($urandom_range(0, 3));
      fr = make_frame(($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01, 5'($urandom),
                      5'($urandom), 16'($urandom));
      write_ctl(8'(spd), 1'b1);
      run_txn(fr, spd, 16'($urandom), 0, 0, 8'd0, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule